// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit I/O virtual address into a 40-bit physical address by walking a three-level table of 64-bit descriptors with 4 KB pages. One table base covers the whole input space, and the walk always begins at level 1. Each request carries an access kind (read, write or execute) and a non-secure flag. The walker fetches descriptors over a simple request/response memory port. It finishes with a one-cycle done pulse that carries either the physical address or a fault code and the level at which the fault was found.

Non-secure requests are checked strictly. Every table descriptor on the path must carry its non-secure-table flag, and the final page descriptor must carry its non-secure flag. A set flag higher up does not excuse a missing one lower down. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, and done and mem_req_valid are 0.
- R2: Descriptor fetch addresses are formed as follows. The level-1 fetch reads base_addr + VA[31:30]*8. The level-2 fetch reads T1 + VA[29:21]*8, and the level-3 fetch reads T2 + VA[20:12]*8. Tn is the value of bits 39:12 of the previous descriptor with twelve zero bits appended.
- R3: A successful walk gives one done pulse of exactly one cycle, with fault = 0, err_code = 0 and pa = {leaf[39:12], VA[11:0]}.
- R4: A descriptor at level n whose bits 1:0 are not 2'b11 ends the walk with fault = 1, err_code = 1 and err_level = n. No further fetch is made.
- R5: On a non-secure request, a table descriptor at level n (1 or 2) with bit 63 clear ends the walk with err_code = 5 and err_level = n.
- R6: On a non-secure request, a leaf with bit 5 clear gives err_code = 5 at err_level = 3. A secure request (req_nonsec = 0) ignores bits 63 and 5 at every level.
- R7: A leaf with bit 10 (access flag) clear gives err_code = 6 at level 3.
- R8: A write (req_acc = 2'b01) to a leaf with bit 7 set gives err_code = 4. A read (req_acc = 2'b00) of the same leaf succeeds.
- R9: An execute (req_acc = 2'b10) to a leaf with either of bits 54:53 set gives err_code = 4. A read of that leaf succeeds, and an execute of a leaf with both bits clear succeeds.
- R10: Only one walk is in flight at a time. req_ready is 0 from the accept until done, and req_valid is ignored while busy. No more than one memory request is outstanding.
- R11: At the leaf, faults are ranked in this order: bad type (1), then secure (5), then access flag (6), then permission (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_nonsec | input | 1 | Request is non-secure |
| base_addr | input | 40 | Level-1 table base |
| mem_req_valid | output | 1 | Descriptor fetch strobe |
| mem_req_addr | output | 40 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor returned |
| mem_rsp_data | input | 64 | Descriptor value |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| pa | output | 40 | Translated physical address |
| err_code | output | 3 | Fault code: 1 translation, 4 permission, 5 secure, 6 access flag |
| err_level | output | 2 | Level (1 to 3) at which the fault was found |

## Verification
A corrupted level counter or table base shows at the ports on the very next fetch, as a wrong mem_req_addr or an extra or missing fetch. The bench logs and compares every fetch address. A wrong latched access kind or non-secure flag shows only at the leaf, as a wrong err_code or an unexpected success in the done cycle. For that reason each permission and security check is run both in its failing and its passing form. A walker that leaves the busy state by mistake shows as a second request being accepted mid-walk, which changes pa and the fetch count.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
  typedef enum logic [1:0] {OUT_NEXT, OUT_LEAF, OUT_FAULT} outcome_e;
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_XLAT  = 3'd1;
  localparam logic [2:0] ERR_PERM  = 3'd4;
  localparam logic [2:0] ERR_SEC   = 3'd5;
  localparam logic [2:0] ERR_AFLAG = 3'd6;

  localparam logic [1:0] LVL_FIRST = 2'd1;
  localparam logic [1:0] LVL_LAST  = 2'd3;

  // descriptor bit positions
  localparam int B_NSTBL = 63;
  localparam int B_XN_HI = 54;
  localparam int B_XN_LO = 53;
  localparam int B_AF    = 10;
  localparam int B_RO    = 7;
  localparam int B_NS    = 5;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [1:0]      level,
  input  logic [PA_W-1:0] tbl_base,
  input  logic [VA_W-1:0] va,
  output logic [PA_W-1:0] desc_addr
);
  localparam int IDX_W  = PAGE_SHIFT - 3;
  localparam int L2_LSB = PAGE_SHIFT + IDX_W;
  localparam int L1_LSB = L2_LSB + IDX_W;

  logic [IDX_W-1:0] idx;
  logic unused_low;
  assign unused_low = ^va[PAGE_SHIFT-1:0];

  always_comb begin
    case (level)
      2'd1:    idx = IDX_W'(va[VA_W-1:L1_LSB]);
      2'd2:    idx = va[L1_LSB-1:L2_LSB];
      default: idx = va[L2_LSB-1:PAGE_SHIFT];
    endcase
    desc_addr = tbl_base + PA_W'({idx, 3'b000});
  end
endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
#(
  parameter int DESC_W     = 64,
  parameter int PA_W       = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        level,
  input  acc_e              acc,
  input  logic              nonsec,
  output outcome_e          kind,
  output logic [2:0]        code,
  output logic [PA_W-1:0]   next_base
);
  logic unused_bits;
  assign unused_bits = ^{desc[B_NSTBL-1:B_XN_HI+1], desc[B_XN_LO-1:PA_W],
                         desc[PAGE_SHIFT-1:B_AF+1], desc[B_AF-1:B_RO+1],
                         desc[B_RO-1:B_NS+1], desc[B_NS-1:2]};

  always_comb begin
    next_base = {desc[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    kind = OUT_NEXT;
    code = ERR_NONE;
    if (desc[1:0] != 2'b11) begin
      kind = OUT_FAULT; code = ERR_XLAT;
    end else if (level != LVL_LAST) begin
      if (nonsec && !desc[B_NSTBL]) begin
        kind = OUT_FAULT; code = ERR_SEC;
      end
    end else if (nonsec && !desc[B_NS]) begin
      kind = OUT_FAULT; code = ERR_SEC;
    end else if (!desc[B_AF]) begin
      kind = OUT_FAULT; code = ERR_AFLAG;
    end else if (acc == ACC_WRITE && desc[B_RO]) begin
      kind = OUT_FAULT; code = ERR_PERM;
    end else if (acc == ACC_EXEC && |desc[B_XN_HI:B_XN_LO]) begin
      kind = OUT_FAULT; code = ERR_PERM;
    end else begin
      kind = OUT_LEAF;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  input  logic              req_nonsec,
  input  logic [PA_W-1:0]   base_addr,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   pa,
  output logic [2:0]        err_code,
  output logic [1:0]        err_level
);
  state_e          st;
  logic [1:0]      level_q;
  logic [VA_W-1:0] va_q;
  acc_e            acc_q;
  logic            nonsec_q;

  logic [1:0]      ag_level;
  logic [PA_W-1:0] ag_base;
  logic [VA_W-1:0] ag_va;
  logic [PA_W-1:0] ag_addr;
  outcome_e        ev_kind;
  logic [2:0]      ev_code;
  logic [PA_W-1:0] ev_next;

  assign req_ready = (st == ST_IDLE);
  assign ag_level  = (st == ST_IDLE) ? LVL_FIRST : level_q + 2'd1;
  assign ag_base   = (st == ST_IDLE) ? base_addr : ev_next;
  assign ag_va     = (st == ST_IDLE) ? req_va : va_q;

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .level(ag_level), .tbl_base(ag_base), .va(ag_va), .desc_addr(ag_addr));

  ptw_desc_eval #(.DESC_W(DESC_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_eval (
    .desc(mem_rsp_data), .level(level_q), .acc(acc_q), .nonsec(nonsec_q),
    .kind(ev_kind), .code(ev_code), .next_base(ev_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      level_q <= 2'd0;
      va_q <= '0;
      acc_q <= ACC_READ;
      nonsec_q <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr <= '0;
      done <= 1'b0;
      fault <= 1'b0;
      pa <= '0;
      err_code <= ERR_NONE;
      err_level <= 2'd0;
    end else begin
      done <= 1'b0;
      mem_req_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_va;
          acc_q <= acc_e'(req_acc);
          nonsec_q <= req_nonsec;
          level_q <= LVL_FIRST;
          mem_req_valid <= 1'b1;
          mem_req_addr <= ag_addr;
          st <= ST_WAIT;
        end
        default: if (mem_rsp_valid) begin
          case (ev_kind)
            OUT_NEXT: begin
              level_q <= level_q + 2'd1;
              mem_req_valid <= 1'b1;
              mem_req_addr <= ag_addr;
            end
            OUT_LEAF: begin
              done <= 1'b1;
              fault <= 1'b0;
              pa <= {mem_rsp_data[PA_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
              err_code <= ERR_NONE;
              err_level <= 2'd0;
              st <= ST_IDLE;
            end
            default: begin
              done <= 1'b1;
              fault <= 1'b1;
              pa <= '0;
              err_code <= ev_code;
              err_level <= level_q;
              st <= ST_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  // R10: a fetch strobe is never repeated back to back (one outstanding)
  assert_single_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R10: accepting a request makes the walker busy
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: every fault names a level
  assert_fault_level_R4: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (err_level != 2'd0));
  // R6: secure faults only arise from non-secure requests
  assert_sec_only_nonsec_R6: assert property (@(posedge clk) disable iff (rst)
    (done && fault && err_code == ERR_SEC) |-> nonsec_q);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic req_nonsec = 1'b0;
  logic [39:0] base_addr = 40'h00_0010_0000;
  logic mem_req_valid;
  logic [39:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic done, fault;
  logic [39:0] pa;
  logic [2:0] err_code;
  logic [1:0] err_level;

  localparam logic [39:0] L2T = 40'h00_0020_0000;
  localparam logic [39:0] L3T = 40'h00_0030_0000;
  localparam logic [39:0] PPG = 40'hAB_CDE1_2000;

  int tests = 0, fails = 0;
  logic [63:0] mem [logic [39:0]];
  logic [39:0] flog [0:255];
  int req_cnt = 0;

  always #5 clk = ~clk;

  ptw_walker u_dut (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    if (mem_req_valid) begin
      mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
      flog[req_cnt[7:0]] <= mem_req_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish (act 0 exp 1)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] a1(input logic [31:0] va); return base_addr + {35'd0, va[31:30], 3'b000}; endfunction
  function automatic logic [39:0] a2(input logic [31:0] va); return L2T + {28'd0, va[29:21], 3'b000}; endfunction
  function automatic logic [39:0] a3(input logic [31:0] va); return L3T + {28'd0, va[20:12], 3'b000}; endfunction

  function automatic logic [63:0] tdesc(input logic [39:0] nxt, input bit ns, input bit ok);
    return {ns, 23'd0, nxt[39:12], 10'd0, ok ? 2'b11 : 2'b00};
  endfunction
  function automatic logic [63:0] leaf(input bit ns, input bit af, input bit ro, input logic [1:0] xn, input logic [1:0] typ);
    return {9'd0, xn, 13'd0, PPG[39:12], 1'b0, af, 2'b00, ro, 1'b0, ns, 3'b000, typ};
  endfunction

  task automatic setup(input logic [31:0] va, input bit ns1, input bit v1, input bit ns2, input bit v2, input logic [63:0] lf);
    mem.delete();
    mem[a1(va)] = tdesc(L2T, ns1, v1);
    mem[a2(va)] = tdesc(L3T, ns2, v2);
    mem[a3(va)] = lf;
  endtask

  logic r_done, r_fault, r_after;
  logic [39:0] r_pa;
  logic [2:0] r_code;
  logic [1:0] r_lvl;
  int r_n, r_start;

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit ns);
    @(negedge clk);
    req_va = va; req_acc = acc; req_nonsec = ns; req_valid = 1'b1; r_start = req_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    r_done = done; r_fault = fault; r_pa = pa; r_code = err_code; r_lvl = err_level;
    r_n = req_cnt - r_start;
    @(negedge clk);
    r_after = done;
  endtask

  task automatic expect_fault(input string tag, input logic [2:0] code, input logic [1:0] lvl, input int nreq);
    chk(r_done && r_fault, tag, {r_done, r_fault}, 2'b11);
    chk(r_code == code, tag, r_code, code);
    chk(r_lvl == lvl, tag, r_lvl, lvl);
    chk(r_n == nreq, tag, r_n, nreq);
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] va);
    chk(r_done && !r_fault, tag, {r_done, r_fault}, 2'b10);
    chk(r_pa == {PPG[39:12], va[11:0]}, tag, r_pa, {PPG[39:12], va[11:0]});
    chk(r_code == 3'd0, tag, r_code, 0);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(done === 1'b0 && mem_req_valid === 1'b0, "R1 idle outputs", {done, mem_req_valid}, 0);
  endtask

  task automatic t_good_walk;
    logic [31:0] va = 32'h9A5C_7ABC;
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b0);
    expect_ok("R3 secure read", va);
    chk(r_after == 1'b0, "R3 done one cycle", r_after, 0);
    chk(r_n == 3, "R2 fetch count", r_n, 3);
    chk(flog[r_start[7:0]] == a1(va), "R2 level1 addr", flog[r_start[7:0]], a1(va));
    chk(flog[8'(r_start + 1)] == a2(va), "R2 level2 addr", flog[8'(r_start + 1)], a2(va));
    chk(flog[8'(r_start + 2)] == a3(va), "R2 level3 addr", flog[8'(r_start + 2)], a3(va));
    // R6: secure request with all non-secure flags clear still succeeded above
  endtask

  task automatic t_nonsec_ok;
    logic [31:0] va = 32'h4123_4FFF;
    setup(va, 1, 1, 1, 1, leaf(1, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b1);
    expect_ok("R5 nonsec all flags set", va);
  endtask

  task automatic t_invalid;
    logic [31:0] va = 32'hC0F0_1234;
    setup(va, 0, 0, 0, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b0);
    expect_fault("R4 invalid level1", 3'd1, 2'd1, 1);
    setup(va, 0, 1, 0, 0, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b0);
    expect_fault("R4 invalid level2", 3'd1, 2'd2, 2);
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b00, 2'b01));
    walk(va, 2'b00, 1'b0);
    expect_fault("R4 invalid leaf type", 3'd1, 2'd3, 3);
  endtask

  task automatic t_nstable;
    logic [31:0] va = 32'h0555_5555;
    setup(va, 0, 1, 1, 1, leaf(1, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b1);
    expect_fault("R5 level1 nstable clear", 3'd5, 2'd1, 1);
    setup(va, 1, 1, 0, 1, leaf(1, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b1);
    expect_fault("R5 level2 nstable clear", 3'd5, 2'd2, 2);
  endtask

  task automatic t_leaf_ns;
    logic [31:0] va = 32'h7FFF_F008;
    setup(va, 1, 1, 1, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b1);
    expect_fault("R6 leaf ns clear", 3'd5, 2'd3, 3);
    walk(va, 2'b00, 1'b0);
    expect_ok("R6 secure ignores ns", va);
  endtask

  task automatic t_aflag;
    logic [31:0] va = 32'h2468_ACE0;
    setup(va, 0, 1, 0, 1, leaf(0, 0, 0, 2'b00, 2'b11));
    walk(va, 2'b00, 1'b0);
    expect_fault("R7 access flag clear", 3'd6, 2'd3, 3);
  endtask

  task automatic t_readonly;
    logic [31:0] va = 32'h8001_2345;
    setup(va, 0, 1, 0, 1, leaf(0, 1, 1, 2'b00, 2'b11));
    walk(va, 2'b01, 1'b0);
    expect_fault("R8 write to read-only", 3'd4, 2'd3, 3);
    walk(va, 2'b00, 1'b0);
    expect_ok("R8 read of read-only", va);
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b01, 1'b0);
    expect_ok("R8 write to writable", va);
  endtask

  task automatic t_xn;
    logic [31:0] va = 32'h3333_3777;
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b10, 2'b11));
    walk(va, 2'b10, 1'b0);
    expect_fault("R9 exec of xn", 3'd4, 2'd3, 3);
    walk(va, 2'b00, 1'b0);
    expect_ok("R9 read of xn", va);
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    walk(va, 2'b10, 1'b0);
    expect_ok("R9 exec allowed", va);
  endtask

  task automatic t_priority;
    logic [31:0] va = 32'hB00B_1E55;
    setup(va, 1, 1, 1, 1, leaf(0, 0, 1, 2'b11, 2'b11));
    walk(va, 2'b01, 1'b1);
    expect_fault("R11 secure beats flag/perm", 3'd5, 2'd3, 3);
    walk(va, 2'b01, 1'b0);
    expect_fault("R11 flag beats perm", 3'd6, 2'd3, 3);
    setup(va, 1, 1, 1, 1, leaf(0, 0, 1, 2'b11, 2'b10));
    walk(va, 2'b01, 1'b1);
    expect_fault("R11 type beats all", 3'd1, 2'd3, 3);
  endtask

  task automatic t_busy;
    logic [31:0] va = 32'h5432_1ABC;
    logic [31:0] vb = 32'hE000_0111;
    int st, n_done;
    setup(va, 0, 1, 0, 1, leaf(0, 1, 0, 2'b00, 2'b11));
    @(negedge clk);
    req_va = va; req_acc = 2'b00; req_nonsec = 1'b0; req_valid = 1'b1; st = req_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 busy ready low", req_ready, 0);
    req_va = vb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n_done = 0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    r_pa = pa;
    for (int i = 0; i < 10; i++) begin
      if (done) n_done++;
      @(negedge clk);
    end
    chk(r_pa == {PPG[39:12], va[11:0]}, "R10 first request result", r_pa, {PPG[39:12], va[11:0]});
    chk(n_done == 1, "R10 single completion", n_done, 1);
    chk(req_cnt - st == 3, "R10 no second walk", req_cnt - st, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_good_walk();
    t_nonsec_ok();
    t_invalid();
    t_nstable();
    t_leaf_ns();
    t_aflag();
    t_readonly();
    t_xn();
    t_priority();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule